// File: doc/BRIEF.md
# Restart and Interrupt Vector Sequencer

This block turns a restart request into a complete call sequence for a small 8-bit processor core. A restart can come from two places. The first is a decoded software restart opcode, which arrives as a strobe with a 3-bit slot code. The second is one of four dedicated hardware request pins, which raise an internal restart without putting any opcode on the bus. The block picks one request at an instruction boundary and computes the 16-bit target address. It pushes the current program counter onto the stack as two byte-wide memory writes, then presents the new program counter and stack pointer for loading.

The software targets are spaced eight bytes apart at the bottom of memory. The hardware targets sit halfway between the upper four software slots. Each hardware target has room for only four bytes, so it is meant to hold a jump. A global interrupt-enable bit gates the three maskable pins. The non-maskable pin is never gated. Accepting any restart clears the enable bit. The sequence changes no condition flags, and the block has no flag interface.

The memory-write port is a valid/ready stream. Once `wr_valid_o` is raised, it stays high, and address and data stay unchanged, until a cycle in which `wr_ready_i` is also high. Only that handshake advances the sequence. Holding `wr_ready_i` low stalls the push for any number of cycles and loses nothing. All other pins are plain level or pulse controls.

Top module: `rstv_seq`

## Requirements
- R1: A software restart with code c (0 to 7 on `sw_code_i`) targets address c*8: the code sits in bits 5:3 of the new PC, and all other bits are zero.
- R2: The hardware pins target fixed addresses: `nmi_i` 0x0024, `irq_lo_i` 0x002C, `irq_mid_i` 0x0034, `irq_hi_i` 0x003C.
- R3: Requests are taken in this order, highest first: `nmi_i`, then `irq_hi_i`, then `irq_mid_i`, then `irq_lo_i`, then the software strobe. A software restart is taken only when no hardware request is eligible.
- R4: When `int_en_o` is 0, the three maskable pins are ignored: nothing is written and no other request is displaced. `nmi_i` is still taken.
- R5: `int_en_o` is 0 after reset. `ie_set_i` sets it. `ie_clr_i` clears it, and clear wins when both are high. Accepting any restart clears it in the same edge that accepts the request.
- R6: The return address is pushed high byte first to SP-1, then low byte to SP-2. The addresses wrap modulo 2^16.
- R7: While `wr_valid_o` is high and `wr_ready_i` is low, `wr_valid_o`, `wr_addr_o` and `wr_data_o` hold their values. The sequence advances only on a cycle where both are high.
- R8: After the last write handshake, `done_o` is high for exactly one cycle. In that cycle `pc_o` carries the target address and `sp_o` carries SP-2. `done_o` is never high in the same cycle as `wr_valid_o`.
- R9: A request is sampled only on a cycle where `boundary_i` is high and the block is idle (`busy_o` low). Requests at any other time have no effect.
- R10: After reset, `wr_valid_o`, `done_o`, `busy_o` and `int_en_o` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| boundary_i | input | 1 | High on an instruction boundary, when a request may be taken |
| sw_valid_i | input | 1 | Decoded software restart opcode present |
| sw_code_i | input | 3 | Slot code of the software restart |
| nmi_i | input | 1 | Non-maskable hardware request |
| irq_lo_i | input | 1 | Maskable hardware request, lowest priority |
| irq_mid_i | input | 1 | Maskable hardware request, middle priority |
| irq_hi_i | input | 1 | Maskable hardware request, highest maskable priority |
| ie_set_i | input | 1 | Set the global interrupt enable |
| ie_clr_i | input | 1 | Clear the global interrupt enable |
| pc_i | input | 16 | Return address to push (current program counter) |
| sp_i | input | 16 | Current stack pointer |
| wr_valid_o | output | 1 | Memory write request valid |
| wr_ready_i | input | 1 | Memory accepts the write this cycle |
| wr_addr_o | output | 16 | Memory write address |
| wr_data_o | output | 8 | Memory write byte |
| done_o | output | 1 | One-cycle pulse: load `pc_o` and `sp_o` |
| pc_o | output | 16 | New program counter (valid with `done_o`) |
| sp_o | output | 16 | New stack pointer (valid with `done_o`) |
| busy_o | output | 1 | A restart sequence is in progress |
| int_en_o | output | 1 | Current global interrupt-enable state |

## Verification
The vector path is tested with each hardware pin alone and with software codes 0, 5 and 7. These patterns show whether the slot code lands in the right bit field and whether the four half-slot targets are distinct. Stacked pin combinations, with and without a software strobe, test the arbitration order at each step. Masked pins paired with a software strobe show that a masked request neither fires nor blocks a lower request. Pseudo-random `wr_ready_i` stalls and a stack pointer near zero test stall-holding and address wrap during the push. Requests raised mid-sequence, or without `boundary_i`, show that sampling is limited to the idle boundary.

// File: rtl/rstv_pkg.sv
package rstv_pkg;
  localparam int unsigned HW_PINS = 4;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PUSH = 2'd1,
    ST_LOAD = 2'd2
  } rstv_state_e;
endpackage

// File: rtl/rstv_arb.sv
module rstv_arb #(
  parameter int unsigned NUM_HW = 4,
  localparam int unsigned IDX_W = (NUM_HW > 1) ? $clog2(NUM_HW) : 1
) (
  input  logic [NUM_HW-1:0] hw_req,
  input  logic              int_en,
  input  logic              sw_valid,
  output logic              take_hw,
  output logic              take_sw,
  output logic [IDX_W-1:0]  hw_idx
);
  // index 0 is non-maskable and highest; among the others the higher index wins
  always_comb begin
    take_hw = 1'b0;
    hw_idx  = '0;
    for (int i = 1; i < int'(NUM_HW); i++) begin
      if (hw_req[i] && int_en) begin
        take_hw = 1'b1;
        hw_idx  = IDX_W'(i);
      end
    end
    if (hw_req[0]) begin
      take_hw = 1'b1;
      hw_idx  = '0;
    end
    take_sw = sw_valid && !take_hw;
  end
endmodule

// File: rtl/rstv_vec.sv
module rstv_vec #(
  parameter int unsigned AW         = 16,
  parameter int unsigned CODE_W     = 3,
  parameter int unsigned SLOT_SHIFT = 3,
  parameter int unsigned NUM_HW     = 4,
  localparam int unsigned IDX_W     = (NUM_HW > 1) ? $clog2(NUM_HW) : 1
) (
  input  logic              is_hw,
  input  logic [IDX_W-1:0]  hw_idx,
  input  logic [CODE_W-1:0] sw_code,
  output logic [AW-1:0]     vector
);
  localparam int unsigned SLOT = 1 << SLOT_SHIFT;

  logic [AW-1:0] hw_tab [NUM_HW];
  logic [AW-1:0] sw_vec;

  // hardware entries sit half a slot above slots NUM_HW .. 2*NUM_HW-1
  for (genvar g = 0; g < int'(NUM_HW); g++) begin : g_hw_tab
    assign hw_tab[g] = AW'((NUM_HW + g) * SLOT + SLOT / 2);
  end

  assign sw_vec = AW'(sw_code) << SLOT_SHIFT;
  assign vector = is_hw ? hw_tab[hw_idx] : sw_vec;
endmodule

// File: rtl/rstv_push.sv
module rstv_push
  import rstv_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 8,
  localparam int unsigned NB    = AW / DW,
  localparam int unsigned CNT_W = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] ret_pc,
  input  logic [AW-1:0] sp_base,
  input  logic [AW-1:0] target,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          done,
  output logic [AW-1:0] pc_out,
  output logic [AW-1:0] sp_out,
  output logic          busy
);
  rstv_state_e      state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [AW-1:0]    ret_q;
  logic [AW-1:0]    sp_q;
  logic [AW-1:0]    tgt_q;
  logic             fire;

  assign fire = wr_valid && wr_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      ret_q   <= '0;
      sp_q    <= '0;
      tgt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start) begin
          state_q <= ST_PUSH;
          cnt_q   <= CNT_W'(NB - 1);
          ret_q   <= ret_pc;
          sp_q    <= sp_base;
          tgt_q   <= target;
        end
        ST_PUSH: if (fire) begin
          if (cnt_q == '0) state_q <= ST_LOAD;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        ST_LOAD: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // byte cnt goes to SP-(NB-cnt): most significant byte lands at SP-1
  assign wr_valid = (state_q == ST_PUSH);
  assign wr_addr  = sp_q - AW'(NB - int'(cnt_q));
  assign wr_data  = DW'(ret_q >> (int'(cnt_q) * DW));
  assign done     = (state_q == ST_LOAD);
  assign pc_out   = tgt_q;
  assign sp_out   = sp_q - AW'(NB);
  assign busy     = (state_q != ST_IDLE);
endmodule

// File: rtl/rstv_seq.sv
module rstv_seq
  import rstv_pkg::*;
#(
  parameter int unsigned AW         = 16,
  parameter int unsigned DW         = 8,
  parameter int unsigned CODE_W     = 3,
  parameter int unsigned SLOT_SHIFT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boundary_i,
  input  logic              sw_valid_i,
  input  logic [CODE_W-1:0] sw_code_i,
  input  logic              nmi_i,
  input  logic              irq_lo_i,
  input  logic              irq_mid_i,
  input  logic              irq_hi_i,
  input  logic              ie_set_i,
  input  logic              ie_clr_i,
  input  logic [AW-1:0]     pc_i,
  input  logic [AW-1:0]     sp_i,
  output logic              wr_valid_o,
  input  logic              wr_ready_i,
  output logic [AW-1:0]     wr_addr_o,
  output logic [DW-1:0]     wr_data_o,
  output logic              done_o,
  output logic [AW-1:0]     pc_o,
  output logic [AW-1:0]     sp_o,
  output logic              busy_o,
  output logic              int_en_o
);
  localparam int unsigned IDX_W = $clog2(HW_PINS);

  logic [HW_PINS-1:0] hw_req;
  logic               take_hw, take_sw, accept, ie_q;
  logic [IDX_W-1:0]   hw_idx;
  logic [AW-1:0]      vector;

  // index order fixes priority: 0 unmaskable, then highest index first
  assign hw_req = {irq_hi_i, irq_mid_i, irq_lo_i, nmi_i};

  rstv_arb #(.NUM_HW(HW_PINS)) u_arb (
    .hw_req  (hw_req),
    .int_en  (ie_q),
    .sw_valid(sw_valid_i),
    .take_hw (take_hw),
    .take_sw (take_sw),
    .hw_idx  (hw_idx)
  );

  rstv_vec #(
    .AW(AW), .CODE_W(CODE_W), .SLOT_SHIFT(SLOT_SHIFT), .NUM_HW(HW_PINS)
  ) u_vec (
    .is_hw  (take_hw),
    .hw_idx (hw_idx),
    .sw_code(sw_code_i),
    .vector (vector)
  );

  assign accept = boundary_i && !busy_o && (take_hw || take_sw);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ie_q <= 1'b0;
    else if (accept)   ie_q <= 1'b0;
    else if (ie_clr_i) ie_q <= 1'b0;
    else if (ie_set_i) ie_q <= 1'b1;
  end
  assign int_en_o = ie_q;

  rstv_push #(.AW(AW), .DW(DW)) u_push (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (accept),
    .ret_pc  (pc_i),
    .sp_base (sp_i),
    .target  (vector),
    .wr_valid(wr_valid_o),
    .wr_ready(wr_ready_i),
    .wr_addr (wr_addr_o),
    .wr_data (wr_data_o),
    .done    (done_o),
    .pc_out  (pc_o),
    .sp_out  (sp_o),
    .busy    (busy_o)
  );
endmodule

// File: rtl/rstv_seq_chk.sv
module rstv_seq_chk #(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          boundary_i,
  input logic          wr_valid_o,
  input logic          wr_ready_i,
  input logic [AW-1:0] wr_addr_o,
  input logic [DW-1:0] wr_data_o,
  input logic          done_o,
  input logic [AW-1:0] pc_o,
  input logic [AW-1:0] sp_o,
  input logic          busy_o,
  input logic          int_en_o
);
  localparam int unsigned NB = AW / DW;

  // R7
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_o && !wr_ready_i) |=> (wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o)));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R8
  done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && wr_valid_o));

  // R5
  ie_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> !int_en_o);

  // R9
  start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(boundary_i));

  // R6
  first_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_valid_o) |-> (wr_addr_o == sp_o + AW'(NB - 1)));

  // R2
  vec_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (pc_o[AW-1:6] == '0 && pc_o[1:0] == 2'b00));
endmodule

bind rstv_seq rstv_seq_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .boundary_i(boundary_i),
  .wr_valid_o(wr_valid_o),
  .wr_ready_i(wr_ready_i),
  .wr_addr_o (wr_addr_o),
  .wr_data_o (wr_data_o),
  .done_o    (done_o),
  .pc_o      (pc_o),
  .sp_o      (sp_o),
  .busy_o    (busy_o),
  .int_en_o  (int_en_o)
);

// File: tb/rstv_seq_bench.sv
module rstv_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        boundary_i = 1'b0, sw_valid_i = 1'b0;
  logic [2:0]  sw_code_i = '0;
  logic        nmi_i = 1'b0, irq_lo_i = 1'b0, irq_mid_i = 1'b0, irq_hi_i = 1'b0;
  logic        ie_set_i = 1'b0, ie_clr_i = 1'b0;
  logic [15:0] pc_i = '0, sp_i = '0;
  logic        wr_valid_o, wr_ready_i = 1'b1;
  logic [15:0] wr_addr_o, pc_o, sp_o;
  logic [7:0]  wr_data_o;
  logic        done_o, busy_o, int_en_o;

  int errors = 0, checks = 0, cycles = 0;
  int ready_mode = 0;
  logic [7:0] lfsr = 8'hA5;

  logic [23:0] exp_wr[$];
  string       wr_tag[$];
  logic [31:0] exp_done[$];
  string       done_tag[$];

  always #4 clk = ~clk;

  rstv_seq u_rstv_seq (.*);

  task automatic check(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // ready driver
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    case (ready_mode)
      1:       wr_ready_i = lfsr[0] & lfsr[2];
      2:       wr_ready_i = 1'b0;
      default: wr_ready_i = 1'b1;
    endcase
  end

  // monitor / scoreboard
  logic        prev_done = 1'b0, held_v = 1'b0;
  logic [15:0] held_a;
  logic [7:0]  held_d;
  always @(negedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      check(1'b0, "R9", "watchdog expired", 32'(cycles), 32'd100000);
      finish_run();
    end
    if (rst_n) begin
      if (held_v) // R7 stall hold
        check(wr_valid_o && wr_addr_o == held_a && wr_data_o == held_d, "R7",
              "stalled write changed", {wr_valid_o, 7'd0, wr_addr_o, wr_data_o},
              {1'b1, 7'd0, held_a, held_d});
      held_v = wr_valid_o && !wr_ready_i;
      held_a = wr_addr_o;
      held_d = wr_data_o;
      if (wr_valid_o && wr_ready_i) begin
        if (exp_wr.size() == 0)
          check(1'b0, "R9", "unexpected write", {8'd0, wr_addr_o, wr_data_o}, 32'd0);
        else begin
          logic [23:0] e;
          string t;
          e = exp_wr.pop_front();
          t = wr_tag.pop_front();
          check({wr_addr_o, wr_data_o} == e, t, "write addr/data",
                {8'd0, wr_addr_o, wr_data_o}, {8'd0, e});
        end
      end
      if (done_o) begin
        check(!prev_done, "R8", "done longer than one cycle", 32'd1, 32'd0);
        if (exp_done.size() == 0)
          check(1'b0, "R9", "unexpected done", {pc_o, sp_o}, 32'd0);
        else begin
          logic [31:0] e;
          string t;
          e = exp_done.pop_front();
          t = done_tag.pop_front();
          check(exp_wr.size() == 0, "R8", "done before all writes",
                32'(exp_wr.size()), 32'd0);
          check({pc_o, sp_o} == e, t, "pc/sp at done", {pc_o, sp_o}, e);
        end
      end
      prev_done = done_o;
    end
  end

  task automatic launch(input logic [3:0] pins, input logic sw, input logic [2:0] code,
                        input logic [15:0] pc, input logic [15:0] sp,
                        input logic go, input logic [15:0] vec, input string tag);
    if (go) begin
      exp_wr.push_back({sp - 16'd1, pc[15:8]}); wr_tag.push_back({tag, "/R6"});
      exp_wr.push_back({sp - 16'd2, pc[7:0]});  wr_tag.push_back({tag, "/R6"});
      exp_done.push_back({vec, sp - 16'd2});    done_tag.push_back({tag, "/R8"});
    end
    @(posedge clk); #1;
    {irq_hi_i, irq_mid_i, irq_lo_i, nmi_i} = pins;
    sw_valid_i = sw; sw_code_i = code; pc_i = pc; sp_i = sp; boundary_i = 1'b1;
    @(posedge clk); #1;
    {irq_hi_i, irq_mid_i, irq_lo_i, nmi_i} = 4'd0;
    sw_valid_i = 1'b0; boundary_i = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (busy_o || exp_done.size() != 0);
  endtask

  task automatic set_ie(input logic s, input logic c);
    @(posedge clk); #1; ie_set_i = s; ie_clr_i = c;
    @(posedge clk); #1; ie_set_i = 1'b0; ie_clr_i = 1'b0;
  endtask

  task automatic expect_idle(input string req);
    @(negedge clk);
    check(!busy_o && !wr_valid_o, req, "request should be ignored",
          {30'd0, busy_o, wr_valid_o}, 32'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R10 reset state
    check({wr_valid_o, done_o, busy_o, int_en_o} == 4'b0, "R10", "reset outputs",
          {28'd0, wr_valid_o, done_o, busy_o, int_en_o}, 32'd0);
    rst_n = 1'b1;

    set_ie(1, 0);
    @(negedge clk); check(int_en_o, "R5", "enable after set", 32'(int_en_o), 32'd1);

    // R1 software vectors
    launch(4'b0000, 1, 3'd5, 16'h1234, 16'h8000, 1, 16'h0028, "R1"); wait_idle();
    check(!int_en_o, "R5", "enable cleared by accept", 32'(int_en_o), 32'd0);
    launch(4'b0000, 1, 3'd0, 16'hBEEF, 16'h4000, 1, 16'h0000, "R1"); wait_idle();
    launch(4'b0000, 1, 3'd7, 16'hA55A, 16'h0001, 1, 16'h0038, "R1"); wait_idle(); // wrap R6

    // R2 hardware vectors; R4 nmi works with enable clear
    launch(4'b0001, 0, 3'd0, 16'h0102, 16'h2000, 1, 16'h0024, "R4"); wait_idle();
    set_ie(1, 0); launch(4'b0010, 0, 3'd0, 16'h0304, 16'h2000, 1, 16'h002C, "R2"); wait_idle();
    set_ie(1, 0); launch(4'b0100, 0, 3'd0, 16'h0506, 16'h2000, 1, 16'h0034, "R2"); wait_idle();
    set_ie(1, 0); launch(4'b1000, 0, 3'd0, 16'h0708, 16'h2000, 1, 16'h003C, "R2"); wait_idle();

    // R3 priority
    set_ie(1, 0); launch(4'b1111, 1, 3'd3, 16'h1111, 16'h3000, 1, 16'h0024, "R3"); wait_idle();
    set_ie(1, 0); launch(4'b1110, 1, 3'd3, 16'h2222, 16'h3000, 1, 16'h003C, "R3"); wait_idle();
    set_ie(1, 0); launch(4'b0110, 0, 3'd0, 16'h3333, 16'h3000, 1, 16'h0034, "R3"); wait_idle();
    set_ie(1, 0); launch(4'b0010, 1, 3'd6, 16'h4444, 16'h3000, 1, 16'h002C, "R3"); wait_idle();

    // R4 masking
    launch(4'b0100, 0, 3'd0, 16'h5555, 16'h3000, 0, 16'h0000, "R4");
    expect_idle("R4");
    launch(4'b1000, 1, 3'd2, 16'h6666, 16'h3000, 1, 16'h0010, "R4"); wait_idle();

    // R9 no boundary
    @(posedge clk); #1; sw_valid_i = 1'b1; sw_code_i = 3'd4; nmi_i = 1'b1;
    @(posedge clk); #1; sw_valid_i = 1'b0; nmi_i = 1'b0;
    expect_idle("R9");

    // R5 set then clear, and clear wins
    set_ie(1, 0); set_ie(0, 1);
    @(negedge clk); check(!int_en_o, "R5", "enable after clear", 32'(int_en_o), 32'd0);
    set_ie(1, 1);
    @(negedge clk); check(!int_en_o, "R5", "clear wins over set", 32'(int_en_o), 32'd0);

    // R7 random back-pressure
    ready_mode = 1;
    for (int k = 0; k < 8; k++) begin
      logic [15:0] pc, sp;
      pc = 16'h9000 + 16'(k * 16'h0123);
      sp = 16'hF000 - 16'(k * 3);
      launch(4'b0000, 1, 3'(k), pc, sp, 1, 16'(k * 8), "R7");
      wait_idle();
    end

    // R9 requests while busy are ignored
    ready_mode = 2;
    launch(4'b0000, 1, 3'd1, 16'hCAFE, 16'h7000, 1, 16'h0008, "R9");
    launch(4'b0001, 1, 3'd2, 16'hDEAD, 16'h7000, 0, 16'h0000, "R9");
    repeat (3) @(posedge clk);
    ready_mode = 0;
    wait_idle();
    repeat (3) @(negedge clk);
    check(!busy_o && exp_wr.size() == 0, "R9", "no second sequence",
          {31'd0, busy_o}, 32'd0);

    repeat (4) @(posedge clk);
    finish_run();
  end
endmodule